// File: doc/BRIEF.md
# Scan Test Pattern Sequencer

This block runs scan test patterns on a logic block that has several parallel scan chains. It drives the shared scan-enable, a scan clock enable and one scan-in bit per chain, and it reads one scan-out bit per chain. Each pattern follows the same order. Scan-enable is raised and the load data is shifted in. Scan-enable is then dropped for a capture window, in which the chains take their functional inputs. After that the captured response is shifted out. The unload of one pattern's response happens during the same shift cycles that load the next pattern.

Pattern words arrive on a valid/ready interface, with one bit per chain per shift cycle. Response words leave on a second valid/ready interface. That interface also carries a per-chain mask that marks which bits are real chain contents. The capture window has two modes: one functional cycle for stuck-at testing, or a configurable run of two or more cycles for transition testing. The chain lengths are parameters. Every shift phase lasts as many cycles as the longest chain, so the shorter chains take leading filler bits.

Top module: `scan_pattern_sequencer`

## Requirements
- R1: In the cycle after a synchronous reset, scan_en, scan_clk_en, busy, pat_ready and resp_valid are all low.
- R2: While a pattern is loading, each shift cycle asserts scan_en and scan_clk_en together, accepts one pattern word (pat_valid and pat_ready both high), and puts that word on scan_in unchanged (bit c goes to chain c).
- R3: A pattern is loaded in exactly MAXLEN accepted shift cycles, where MAXLEN is the longest chain length. The capture window begins in the next active cycle.
- R4: In stuck-at mode (mode_transition = 0, latched at start), the capture window is exactly one cycle with scan_clk_en high and scan_en low.
- R5: In transition mode, the capture window lasts cap_cycles cycles. A cap_cycles value below 2 is treated as 2.
- R6: No response word is offered (resp_valid stays low) while the first pattern of a run is loading.
- R7: Unload shift k of a captured pattern happens in the same cycle as load shift k of the next pattern. resp_bits carries scan_out as it was before that shift, so chain c delivers its flop at distance k from its scan-out end.
- R8: For unload shift k (k = 0 for the first response word), resp_mask bit c is high exactly when k is less than the length of chain c. The filler positions of shorter chains are flagged low.
- R9: No shift happens while a needed pattern word is not valid, or while a pending response word is not accepted. scan_clk_en stays low in those cycles, so no bit is lost or duplicated.
- R10: A pattern whose words carry pat_last is the final one. After its capture, its response is shifted out with scan_in at 0 and pat_ready low. The block then spends one cycle with scan_en low and returns to idle, with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run while idle; mode and capture count are latched here |
| mode_transition | input | 1 | 0: single-cycle capture, 1: multi-cycle capture |
| cap_cycles | input | CAPW | Capture length in transition mode (minimum 2) |
| pat_valid | input | 1 | Pattern word valid |
| pat_ready | output | 1 | Pattern word accepted this cycle |
| pat_bits | input | NCH | Pattern word, bit c for chain c |
| pat_last | input | 1 | Word belongs to the final pattern |
| resp_valid | output | 1 | Response word valid |
| resp_ready | input | 1 | Response word consumer ready |
| resp_bits | output | NCH | Response word, bit c from chain c |
| resp_mask | output | NCH | Bit c high when resp_bits[c] is a real chain bit |
| scan_en | output | 1 | Shared scan-enable |
| scan_clk_en | output | 1 | Clock enable of all scan flops |
| scan_in | output | NCH | Serial inputs, one per chain |
| scan_out | input | NCH | Serial outputs, one per chain |
| busy | output | 1 | High from start until the run is back in idle |

## Verification
The chains under test have lengths 7, 3 and 5 and are joined by a fixed combinational function. A wrong load order, a wrong capture count or a misplaced filler bit therefore changes the captured values. Runs use stuck-at mode, transition mode with three cycles, and transition mode with a count of zero that must be raised to two. Each mode separates single from repeated application of the function. The stall pattern holds back pattern words and response acceptance on different cycle periods. This checks that input starvation and output back-pressure each freeze the shift on their own. Single-pattern and multi-pattern runs show the difference between the first load with no response, overlapped load and unload, and the final zero-fill drain.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SHIFT   = 2'd1,
      ST_CAPTURE = 2'd2,
      ST_DONE    = 2'd3
   } seq_state_e;

   // smallest legal capture length in multi-cycle mode
   localparam int unsigned MIN_TRANSITION_CAP = 2;

endpackage

// File: rtl/scan_seq_shift_ctr.sv
module scan_seq_shift_ctr #(
   parameter int MAXLEN = 7,
   parameter int W      = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   localparam logic [W-1:0] LAST = W'(MAXLEN - 1);

   generate
      if (MAXLEN < 1) begin : g_bad_len
         $error("scan_seq_shift_ctr: MAXLEN must be at least 1");
      end
      if (MAXLEN > (1 << W) - 1) begin : g_bad_width
         $error("scan_seq_shift_ctr: W too narrow for MAXLEN");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   assign wrap = adv && (cnt_q == LAST);
   assign cnt  = cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end

   // R3: the shift position never reaches the longest chain length
   a_r3_shift_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);

endmodule

// File: rtl/scan_seq_capture_ctr.sv
module scan_seq_capture_ctr
   import scan_seq_pkg::*;
#(
   parameter int CAPW = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic            transition,
   input  logic [CAPW-1:0] cfg_cycles,
   input  logic            run,
   output logic            last
);

   localparam logic [CAPW-1:0] MIN_CAP = CAPW'(MIN_TRANSITION_CAP);

   generate
      if (CAPW < 2) begin : g_bad_capw
         $error("scan_seq_capture_ctr: CAPW must hold at least the value 2");
      end
   endgenerate

   logic [CAPW-1:0] ncap_q;
   logic [CAPW-1:0] cnt_q;
   logic            mode_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ncap_q <= CAPW'(1);
         mode_q <= 1'b0;
      end else if (load) begin
         mode_q <= transition;
         if (!transition) begin
            ncap_q <= CAPW'(1);
         end else if (cfg_cycles < MIN_CAP) begin
            ncap_q <= MIN_CAP;
         end else begin
            ncap_q <= cfg_cycles;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last = run && (cnt_q == ncap_q - 1'b1);

   // R4: single-cycle mode finishes on its first capture cycle
   a_r4_single_capture: assert property (@(posedge clk) disable iff (rst)
      (run && !mode_q) |-> last);

   // R5: multi-cycle mode never ends on its first capture cycle
   a_r5_min_two_cycles: assert property (@(posedge clk) disable iff (rst)
      (run && mode_q && cnt_q == '0) |-> !last);

   // R5: the window never runs past its latched length
   a_r5_capture_bound: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt_q < ncap_q));

endmodule

// File: rtl/scan_seq_pad_mask.sv
module scan_seq_pad_mask #(
   parameter int                  NCH        = 3,
   parameter int                  LENW       = 8,
   parameter logic [NCH*LENW-1:0] CHAIN_LENS = '0,
   parameter bit                  BALANCED   = 1'b0
) (
   input  logic [LENW-1:0] pos,
   output logic [NCH-1:0]  mask
);

   generate
      if (BALANCED) begin : g_balanced
         // equal chains: every unload position carries real data
         assign mask = '1;
      end else begin : g_padded
         for (genvar c = 0; c < NCH; c++) begin : g_chain
            localparam logic [LENW-1:0] LC = CHAIN_LENS[c*LENW +: LENW];
            assign mask[c] = (pos < LC);
         end
      end
   endgenerate

endmodule

// File: rtl/scan_pattern_sequencer.sv
module scan_pattern_sequencer
   import scan_seq_pkg::*;
#(
   parameter int                  NCH        = 3,
   parameter int                  LENW       = 8,
   parameter logic [NCH*LENW-1:0] CHAIN_LENS = {8'd5, 8'd3, 8'd7},
   parameter int                  CAPW       = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic            mode_transition,
   input  logic [CAPW-1:0] cap_cycles,
   input  logic            pat_valid,
   output logic            pat_ready,
   input  logic [NCH-1:0]  pat_bits,
   input  logic            pat_last,
   output logic            resp_valid,
   input  logic            resp_ready,
   output logic [NCH-1:0]  resp_bits,
   output logic [NCH-1:0]  resp_mask,
   output logic            scan_en,
   output logic            scan_clk_en,
   output logic [NCH-1:0]  scan_in,
   input  logic [NCH-1:0]  scan_out,
   output logic            busy
);

   function automatic int chain_len(input int c);
      return int'(CHAIN_LENS[c*LENW +: LENW]);
   endfunction

   function automatic int calc_max();
      int m = 0;
      for (int c = 0; c < NCH; c++) if (chain_len(c) > m) m = chain_len(c);
      return m;
   endfunction

   function automatic int calc_min();
      int m = chain_len(0);
      for (int c = 1; c < NCH; c++) if (chain_len(c) < m) m = chain_len(c);
      return m;
   endfunction

   localparam int MAXLEN   = calc_max();
   localparam int MINLEN   = calc_min();
   localparam bit BALANCED = (MAXLEN == MINLEN);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("scan_pattern_sequencer: NCH must be at least 1");
      end
      for (genvar c = 0; c < NCH; c++) begin : g_len_check
         if (CHAIN_LENS[c*LENW +: LENW] == '0) begin : g_zero
            $error("scan_pattern_sequencer: a chain length is zero");
         end
      end
   endgenerate

   seq_state_e state_q;
   logic       in_need_q;    // a pattern is being loaded
   logic       have_resp_q;  // a captured response sits in the chains
   logic       final_q;      // current pattern is the last of the run

   logic            in_ok, out_ok, fire, wrap, cap_last, cap_run, launch;
   logic [LENW-1:0] pos;
   logic [NCH-1:0]  pad_mask;

   assign launch  = (state_q == ST_IDLE) && start;
   assign cap_run = (state_q == ST_CAPTURE);
   assign in_ok   = !in_need_q || pat_valid;
   assign out_ok  = !have_resp_q || resp_ready;
   assign fire    = (state_q == ST_SHIFT) && in_ok && out_ok;

   scan_seq_shift_ctr #(
      .MAXLEN (MAXLEN),
      .W      (LENW)
   ) u_shift (
      .clk  (clk),
      .rst  (rst),
      .clr  (launch),
      .adv  (fire),
      .cnt  (pos),
      .wrap (wrap)
   );

   scan_seq_capture_ctr #(
      .CAPW (CAPW)
   ) u_capture (
      .clk        (clk),
      .rst        (rst),
      .load       (launch),
      .transition (mode_transition),
      .cfg_cycles (cap_cycles),
      .run        (cap_run),
      .last       (cap_last)
   );

   scan_seq_pad_mask #(
      .NCH        (NCH),
      .LENW       (LENW),
      .CHAIN_LENS (CHAIN_LENS),
      .BALANCED   (BALANCED)
   ) u_mask (
      .pos  (pos),
      .mask (pad_mask)
   );

   // scan side
   assign scan_en     = (state_q == ST_SHIFT);
   assign scan_clk_en = fire || cap_run;
   assign scan_in     = (scan_en && in_need_q) ? pat_bits : '0;

   // stream side
   assign pat_ready  = scan_en && in_need_q && out_ok;
   assign resp_valid = scan_en && have_resp_q && in_ok;
   assign resp_bits  = scan_out;
   assign resp_mask  = pad_mask & {NCH{resp_valid}};
   assign busy       = (state_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         in_need_q   <= 1'b0;
         have_resp_q <= 1'b0;
         final_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q     <= ST_SHIFT;
                  in_need_q   <= 1'b1;
                  have_resp_q <= 1'b0;
                  final_q     <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (fire && in_need_q && pat_last) final_q <= 1'b1;
               if (wrap) state_q <= in_need_q ? ST_CAPTURE : ST_DONE;
            end
            ST_CAPTURE: begin
               if (cap_last) begin
                  state_q     <= ST_SHIFT;
                  have_resp_q <= 1'b1;
                  in_need_q   <= !final_q;
               end
            end
            ST_DONE: begin
               state_q     <= ST_IDLE;
               in_need_q   <= 1'b0;
               have_resp_q <= 1'b0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1: the scan side is quiet right after reset
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!scan_en && !scan_clk_en && !busy));

   // R2: every load shift consumes exactly one handshaken word
   a_r2_load_handshake: assert property (@(posedge clk) disable iff (rst)
      (scan_en && scan_clk_en && in_need_q) |-> (pat_valid && pat_ready));

   // R9: a stalled shift cycle leaves the shift position untouched
   a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
      (scan_en && !scan_clk_en) |=> $stable(pos));

   // R7: an accepted response word always moves the chains
   a_r7_unload_lockstep: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && resp_ready) |-> scan_clk_en);

   // R10: the drain cycle is followed by idle
   a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
      (busy && !scan_en && !scan_clk_en) |=> !busy);

endmodule

// File: tb/tb_scan_pattern_sequencer.sv
module tb_scan_pattern_sequencer;

   localparam int NCH = 3;
   localparam int M   = 7;
   localparam int L0 = 7, L1 = 3, L2 = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       mode_transition = 1'b0;
   logic [3:0] cap_cycles = '0;
   logic       pat_valid = 1'b0;
   logic       pat_ready;
   logic [2:0] pat_bits = '0;
   logic       pat_last = 1'b0;
   logic       resp_valid;
   logic       resp_ready = 1'b1;
   logic [2:0] resp_bits, resp_mask;
   logic       scan_en, scan_clk_en;
   logic [2:0] scan_in, scan_out;
   logic       busy;

   // circuit under test: three chains joined by fixed logic
   logic [6:0] c0 = '0;
   logic [2:0] c1 = '0;
   logic [4:0] c2 = '0;

   int checks = 0, fails = 0, cyc = 0;

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   scan_pattern_sequencer dut (
      .clk(clk), .rst(rst), .start(start), .mode_transition(mode_transition),
      .cap_cycles(cap_cycles), .pat_valid(pat_valid), .pat_ready(pat_ready),
      .pat_bits(pat_bits), .pat_last(pat_last), .resp_valid(resp_valid),
      .resp_ready(resp_ready), .resp_bits(resp_bits), .resp_mask(resp_mask),
      .scan_en(scan_en), .scan_clk_en(scan_clk_en), .scan_in(scan_in),
      .scan_out(scan_out), .busy(busy)
   );

   function automatic logic [14:0] fx(input logic [14:0] s);
      logic [6:0] a; logic [2:0] b; logic [4:0] d;
      logic [6:0] n0; logic [2:0] n1; logic [4:0] n2;
      a = s[6:0]; b = s[9:7]; d = s[14:10];
      n0 = {a[5:0], b[2]} ^ {d, b[1:0]};
      n1 = a[6:4] ^ d[2:0];
      n2 = {d[3:0], d[4]} ^ a[4:0] ^ {2'b00, b};
      return {n2, n1, n0};
   endfunction

   assign scan_out = {c2[4], c1[2], c0[6]};

   always @(posedge clk) begin
      if (scan_clk_en) begin
         if (scan_en) begin
            c0 <= {c0[5:0], scan_in[0]};
            c1 <= {c1[1:0], scan_in[1]};
            c2 <= {c2[3:0], scan_in[2]};
         end else begin
            {c2, c1, c0} <= fx({c2, c1, c0});
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   logic [2:0] pw [0:3][0:6];
   logic [2:0] ew [0:3][0:6];

   task automatic run_seq(input bit tr, input int cfg, input int np,
                          input bit stall, input int seed);
      int ncap, ld, ul, caps, caprun, guard, done_cyc;
      bit loading, avail, stall_exp;
      logic [14:0] st;
      logic [2:0] em;
      ncap = !tr ? 1 : (cfg < 2 ? 2 : cfg);
      for (int p = 0; p < np; p++) begin
         for (int k = 0; k < M; k++)
            pw[p][k] = 3'((p * 5 + k * 3 + seed + k * k * (p + 1)) % 8);
         st = '0;
         for (int j = 0; j < L0; j++) st[j]      = pw[p][M-1-j][0];
         for (int j = 0; j < L1; j++) st[7 + j]  = pw[p][M-1-j][1];
         for (int j = 0; j < L2; j++) st[10 + j] = pw[p][M-1-j][2];
         for (int n = 0; n < ncap; n++) st = fx(st);
         for (int k = 0; k < M; k++) begin
            ew[p][k][0] = (k < L0) ? st[L0-1-k]      : 1'b0;
            ew[p][k][1] = (k < L1) ? st[7 + L1-1-k]  : 1'b0;
            ew[p][k][2] = (k < L2) ? st[10 + L2-1-k] : 1'b0;
         end
      end
      @(negedge clk);
      mode_transition = tr; cap_cycles = 4'(cfg); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ld = 0; ul = 0; caps = 0; caprun = 0; guard = 0; done_cyc = 0;
      forever begin
         loading    = ld < np * M;
         pat_valid  = loading && !(stall && (cyc % 3 == 1));
         pat_bits   = loading ? pw[ld / M][ld % M] : 3'b101;
         pat_last   = loading && (ld / M == np - 1);
         resp_ready = !(stall && (cyc % 4 == 2));
         #1;
         if (ul == np * M && !busy) break;
         guard++;
         if (guard > 2000) begin
            chk(1'b0, "R9", "run did not finish", guard, 0);
            break;
         end
         avail = ul < caps * M;
         if (ul == np * M) begin
            done_cyc++;
            chk(!scan_en && !scan_clk_en, "R10", "drain cycle scan_en", scan_en, 0);
         end else if (scan_clk_en && !scan_en) begin
            caprun++;
            if (caprun == 1)
               chk(ld == (caps + 1) * M, "R3", "words before capture", ld, (caps + 1) * M);
         end else if (scan_en) begin
            if (caprun > 0) begin
               chk(caprun == ncap, tr ? "R5" : "R4", "capture cycles", caprun, ncap);
               caps++; caprun = 0;
               avail = ul < caps * M;
            end
            stall_exp = (loading && !pat_valid) || (avail && !resp_ready);
            chk(scan_clk_en == !stall_exp, "R9", "shift enable vs stall",
                scan_clk_en, !stall_exp);
            if (scan_clk_en) begin
               if (loading) begin
                  chk(pat_ready && scan_in == pw[ld / M][ld % M], "R2", "scan_in load",
                      scan_in, pw[ld / M][ld % M]);
                  ld++;
               end else begin
                  chk(!pat_ready && scan_in == 3'b000, "R10", "scan_in drain", scan_in, 0);
               end
               if (avail) begin
                  em = {3'(ul % M < L2), 3'(ul % M < L1) & 3'b1, 1'b0};
                  em = {ul % M < L2, ul % M < L1, ul % M < L0};
                  chk(resp_valid, "R7", "resp_valid on unload", resp_valid, 1);
                  chk(resp_mask == em, "R8", "filler mask", resp_mask, em);
                  chk((resp_bits & em) == (ew[ul / M][ul % M] & em), "R7", "response bits",
                      resp_bits & em, ew[ul / M][ul % M] & em);
                  ul++;
               end else begin
                  chk(!resp_valid, "R6", "no response on first load", resp_valid, 0);
               end
            end
         end else begin
            chk(1'b0, "R2", "unexpected idle while busy", busy, 0);
         end
         @(negedge clk);
      end
      chk(done_cyc == 1, "R10", "drain cycles", done_cyc, 1);
      chk(!busy && !scan_en, "R10", "back to idle", busy, 0);
      pat_valid = 1'b0; pat_last = 1'b0; resp_ready = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!scan_en && !scan_clk_en && !busy && !pat_ready && !resp_valid,
          "R1", "outputs in reset", {scan_en, scan_clk_en, busy}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(!scan_en && !scan_clk_en && !busy, "R1", "idle after reset",
          {scan_en, scan_clk_en, busy}, 0);
      run_seq(1'b0, 0, 3, 1'b0, 1);   // stuck-at, free running
      run_seq(1'b1, 3, 2, 1'b1, 4);   // transition, three cycles, stalls
      run_seq(1'b1, 0, 2, 1'b1, 6);   // transition, count raised to two
      run_seq(1'b0, 0, 1, 1'b1, 3);   // single pattern
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      checks++; fails++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule